// File: doc/BRIEF.md
# Receive Descriptor Ring Sequencer

This block steps a receive DMA engine through a chain of descriptors kept in system memory. Each descriptor is four 32-bit words at a 16-byte stride. Word 0 carries the control flags and a received-length field, word 1 the buffer length, word 2 the buffer address, and word 3 is unused. Software fills in a descriptor and sets its ownership bit. The engine fetches the descriptor through a word-wide memory port, hands the buffer to a separate data mover with a request/done handshake, and writes word 0 back with ownership returned to software. It then moves on to the next descriptor.

Software controls two things: a receive-enable bit and a list base address. Setting the enable bit while the engine is idle makes it start at the base address. A per-descriptor list-end flag picks the next descriptor. With the flag clear, the next descriptor is the following one in memory. With it set, the engine wraps back to the base address. If the engine meets a descriptor it does not own, it clears the enable bit itself, raises a halt flag and keeps its pointer. Enabling it again makes it retry that same descriptor.

Top module: `rx_desc_seq`

## Requirements
- R1: After reset, rxen and halted are 0, cur_ptr is 0, and neither mem_req nor mv_req is asserted.
- R2: When software sets rxen while the engine is idle and not resuming from a halt, cur_ptr is loaded from the list base address.
- R3: While frame_avail is 0, the engine issues no descriptor read, even with rxen set.
- R4: For a descriptor it owns (word 0 bit 31 = 1), the engine reads words 0, 1 and 2 at cur_ptr, cur_ptr+4 and cur_ptr+8. It then raises mv_req with mv_addr = word 2 and mv_len = word 1 bits 15:0, holds both steady until mv_done, and makes no memory access while mv_req is high.
- R5: After mv_done, the engine writes word 0 at cur_ptr. In the written value, bit 31 is 0, bits 30:16 are unchanged, and bits 15:0 hold the mv_cnt value returned with mv_done.
- R6: After the write-back, if word 0 bit 30 (list end) is 0, cur_ptr advances by 16.
- R7: After the write-back, if word 0 bit 30 is 1, cur_ptr reloads from the list base address.
- R8: A fetched word 0 with bit 31 = 0 clears rxen and sets halted. In that case the engine raises no mv_req, writes nothing to memory and leaves cur_ptr unchanged.
- R9: Setting rxen after a halt clears halted and makes the engine re-fetch the descriptor at the held cur_ptr, not at the base address.
- R10: If software clears rxen while a descriptor is in progress, that descriptor still completes and is written back, and then the engine fetches no further descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_rxen_wr | input | 1 | Software write strobe for the receive-enable bit |
| sw_rxen_val | input | 1 | Value written to the receive-enable bit |
| sw_base_wr | input | 1 | Software write strobe for the list base address |
| sw_base_val | input | AW | List base address value |
| frame_avail | input | 1 | A received frame is waiting for a buffer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| mv_req | output | 1 | Data-move request to the data mover |
| mv_addr | output | AW | Buffer address for the move |
| mv_len | output | LW | Buffer length for the move |
| mv_done | input | 1 | One-cycle pulse: move finished |
| mv_cnt | input | LW | Bytes received, valid with mv_done |
| rxen | output | 1 | Receive-enable bit as seen by software |
| halted | output | 1 | Engine stopped on a descriptor it does not own |
| cur_ptr | output | AW | Address of the current descriptor |

## Verification
The assertions check on every cycle the properties that depend only on the current and previous cycle. Every write-back returns ownership and targets cur_ptr. A pending move request holds its address and length, and no memory access overlaps it. A halt drops rxen, and a halted engine stays quiet on both ports. The pointer walk needs the bench's scenarios: stepping through contiguous descriptors, wrapping on a list-end flag, stopping on a descriptor already returned to software, and resuming at the held pointer rather than the base. The same goes for the preserved software fields in the written-back word, the absence of fetches without a frame, and the orderly stop after software drops rxen mid-transfer.

// File: rtl/rxds_pkg.sv
package rxds_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_RD0,
      ST_RD1,
      ST_RD2,
      ST_MOVE,
      ST_WB
   } rxds_state_e;
endpackage

// File: rtl/rxds_regs.sv
module rxds_regs #(
   parameter int AW         = 32,
   parameter int STRIDE     = 16,
   parameter bit ALIGN_BASE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_rxen_wr,
   input  logic          sw_rxen_val,
   input  logic          sw_base_wr,
   input  logic [AW-1:0] sw_base_val,
   input  logic          hw_halt,
   input  logic          go,
   output logic          rxen,
   output logic [AW-1:0] base,
   output logic          halted,
   output logic          resume
);
   localparam int LOW = $clog2(STRIDE);

   logic [AW-1:0] base_in;

   generate
      if (ALIGN_BASE) begin : g_align
         assign base_in = {sw_base_val[AW-1:LOW], {LOW{1'b0}}};
      end else begin : g_raw
         assign base_in = sw_base_val;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base <= '0;
      end else if (sw_base_wr) begin
         base <= base_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxen   <= 1'b0;
         halted <= 1'b0;
         resume <= 1'b0;
      end else if (hw_halt) begin
         rxen   <= 1'b0;
         halted <= 1'b1;
         resume <= 1'b1;
      end else begin
         if (sw_rxen_wr) begin
            rxen <= sw_rxen_val;
            if (sw_rxen_val) halted <= 1'b0;
         end
         if (go) resume <= 1'b0;
      end
   end
endmodule

// File: rtl/rxds_ptr.sv
module rxds_ptr #(
   parameter int AW     = 32,
   parameter int STRIDE = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_base,
   input  logic [AW-1:0] base,
   input  logic          adv,
   input  logic          lend,
   output logic [AW-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (ld_base) begin
         ptr <= base;
      end else if (adv) begin
         ptr <= lend ? base : ptr + AW'(STRIDE);
      end
   end
endmodule

// File: rtl/rxds_fsm.sv
module rxds_fsm
   import rxds_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int LW        = 16,
   parameter int VALID_BIT = 31,
   parameter int LEND_BIT  = 30
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rxen,
   input  logic          frame_avail,
   input  logic [AW-1:0] ptr,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   output logic          mv_req,
   output logic [AW-1:0] mv_addr,
   output logic [LW-1:0] mv_len,
   input  logic          mv_done,
   input  logic [LW-1:0] mv_cnt,
   output logic          go,
   output logic          hw_halt,
   output logic          adv,
   output logic          lend
);
   localparam int WSTEP = DW / 8;

   rxds_state_e   st;
   logic [DW-1:0] w0_q;
   logic [LW-1:0] len_q;
   logic [AW-1:0] bufa_q;
   logic [LW-1:0] cnt_q;

   assign go      = (st == ST_IDLE) && rxen;
   assign hw_halt = (st == ST_RD0) && mem_ack && !mem_rdata[VALID_BIT];
   assign adv     = (st == ST_WB) && mem_ack;
   assign lend    = w0_q[LEND_BIT];

   assign mv_req  = (st == ST_MOVE);
   assign mv_addr = bufa_q;
   assign mv_len  = len_q;

   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = ptr;
      unique case (st)
         ST_RD0: mem_req = 1'b1;
         ST_RD1: begin mem_req = 1'b1; mem_addr = ptr + AW'(WSTEP); end
         ST_RD2: begin mem_req = 1'b1; mem_addr = ptr + AW'(2*WSTEP); end
         ST_WB:  begin mem_req = 1'b1; mem_we = 1'b1; end
         default: ;
      endcase
      mem_wdata                = w0_q;
      mem_wdata[VALID_BIT]     = 1'b0;
      mem_wdata[LW-1:0]        = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         w0_q   <= '0;
         len_q  <= '0;
         bufa_q <= '0;
         cnt_q  <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (rxen) st <= ST_WAIT;
            ST_WAIT: begin
               if (!rxen)           st <= ST_IDLE;
               else if (frame_avail) st <= ST_RD0;
            end
            ST_RD0: if (mem_ack) begin
               w0_q <= mem_rdata;
               st   <= mem_rdata[VALID_BIT] ? ST_RD1 : ST_IDLE;
            end
            ST_RD1: if (mem_ack) begin
               len_q <= mem_rdata[LW-1:0];
               st    <= ST_RD2;
            end
            ST_RD2: if (mem_ack) begin
               bufa_q <= mem_rdata[AW-1:0];
               st     <= ST_MOVE;
            end
            ST_MOVE: if (mv_done) begin
               cnt_q <= mv_cnt;
               st    <= ST_WB;
            end
            ST_WB: if (mem_ack) st <= ST_WAIT;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rx_desc_seq.sv
module rx_desc_seq #(
   parameter int AW         = 32,
   parameter int LW         = 16,
   parameter int VALID_BIT  = 31,
   parameter int LEND_BIT   = 30,
   parameter bit ALIGN_BASE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_rxen_wr,
   input  logic          sw_rxen_val,
   input  logic          sw_base_wr,
   input  logic [AW-1:0] sw_base_val,
   input  logic          frame_avail,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_ack,
   input  logic [31:0]   mem_rdata,
   output logic          mv_req,
   output logic [AW-1:0] mv_addr,
   output logic [LW-1:0] mv_len,
   input  logic          mv_done,
   input  logic [LW-1:0] mv_cnt,
   output logic          rxen,
   output logic          halted,
   output logic [AW-1:0] cur_ptr
);
   localparam int DW     = 32;
   localparam int STRIDE = 4 * (DW / 8);

   initial begin
      if (AW < 8 || AW > DW)
         $error("rx_desc_seq: AW must lie in 8..32");
      if (LW < 1 || LW >= LEND_BIT)
         $error("rx_desc_seq: LW must stay below the flag bits");
      if (VALID_BIT >= DW || LEND_BIT >= VALID_BIT)
         $error("rx_desc_seq: flag bit positions out of order");
   end

   logic          go, hw_halt, adv, lend, resume;
   logic [AW-1:0] base;

   rxds_regs #(.AW(AW), .STRIDE(STRIDE), .ALIGN_BASE(ALIGN_BASE)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .sw_rxen_wr(sw_rxen_wr), .sw_rxen_val(sw_rxen_val),
      .sw_base_wr(sw_base_wr), .sw_base_val(sw_base_val),
      .hw_halt(hw_halt), .go(go),
      .rxen(rxen), .base(base), .halted(halted), .resume(resume)
   );

   rxds_ptr #(.AW(AW), .STRIDE(STRIDE)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .ld_base(go && !resume), .base(base),
      .adv(adv), .lend(lend), .ptr(cur_ptr)
   );

   rxds_fsm #(.AW(AW), .DW(DW), .LW(LW), .VALID_BIT(VALID_BIT), .LEND_BIT(LEND_BIT)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .rxen(rxen), .frame_avail(frame_avail), .ptr(cur_ptr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len),
      .mv_done(mv_done), .mv_cnt(mv_cnt),
      .go(go), .hw_halt(hw_halt), .adv(adv), .lend(lend)
   );
endmodule

// File: rtl/rx_desc_seq_chk.sv
module rx_desc_seq_chk #(
   parameter int AW        = 32,
   parameter int LW        = 16,
   parameter int VALID_BIT = 31
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [31:0]   mem_wdata,
   input logic          mv_req,
   input logic [AW-1:0] mv_addr,
   input logic [LW-1:0] mv_len,
   input logic          mv_done,
   input logic          rxen,
   input logic          halted,
   input logic [AW-1:0] cur_ptr
);
   p_wb_clears_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> !mem_wdata[VALID_BIT]);

   p_wb_at_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_addr == cur_ptr);

   p_mv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mv_req && !mv_done |=> mv_req && $stable(mv_addr) && $stable(mv_len));

   p_no_mem_in_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mv_req |-> !mem_req);

   p_halt_drops_rxen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> !rxen);

   p_halted_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_req && !mv_req);
endmodule

bind rx_desc_seq rx_desc_seq_chk #(.AW(AW), .LW(LW), .VALID_BIT(VALID_BIT)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len), .mv_done(mv_done),
   .rxen(rxen), .halted(halted), .cur_ptr(cur_ptr)
);

// File: tb/rx_desc_seq_test.sv
module rx_desc_seq_test;
   localparam int AW = 32;
   localparam int LW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sw_rxen_wr = 1'b0, sw_rxen_val = 1'b0;
   logic          sw_base_wr = 1'b0;
   logic [AW-1:0] sw_base_val = '0;
   logic          frame_avail = 1'b0;
   logic          mem_req, mem_we, mem_ack;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata, mem_rdata;
   logic          mv_req;
   logic [AW-1:0] mv_addr;
   logic [LW-1:0] mv_len;
   logic          mv_done = 1'b0;
   logic [LW-1:0] mv_cnt = '0;
   logic          rxen, halted;
   logic [AW-1:0] cur_ptr;

   always #10 clk = ~clk;

   rx_desc_seq #(.AW(AW), .LW(LW)) uut (
      .clk(clk), .rst_n(rst_n),
      .sw_rxen_wr(sw_rxen_wr), .sw_rxen_val(sw_rxen_val),
      .sw_base_wr(sw_base_wr), .sw_base_val(sw_base_val),
      .frame_avail(frame_avail),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len),
      .mv_done(mv_done), .mv_cnt(mv_cnt),
      .rxen(rxen), .halted(halted), .cur_ptr(cur_ptr)
   );

   // memory model: single-cycle acknowledge
   logic [31:0] mem [256];
   assign mem_ack   = mem_req;
   assign mem_rdata = mem[mem_addr[9:2]];
   int reads = 0;
   always @(posedge clk) begin
      if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      if (mem_req && !mem_we) reads <= reads + 1;
   end

   // data mover model: done three cycles after the request, count = len - 4
   logic busy = 1'b0;
   int   dly = 0;
   always @(posedge clk) begin
      mv_done <= 1'b0;
      if (mv_req && !mv_done && !busy) begin
         busy <= 1'b1;
         dly  <= 0;
      end else if (busy) begin
         dly <= dly + 1;
         if (dly == 2) begin
            mv_done <= 1'b1;
            mv_cnt  <= mv_len - 16'd4;
            busy    <= 1'b0;
         end
      end
   end

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // scoreboard: expected moves {ptr, addr, len}
   logic [95:0] exp_q[$];
   int moves = 0;
   logic mv_req_d = 1'b0;

   task automatic expect_move(input logic [31:0] p, input logic [31:0] a, input logic [31:0] l);
      exp_q.push_back({p, a, l});
   endtask

   always @(negedge clk) begin
      mv_req_d <= mv_req;
      if (rst_n && mv_req && !mv_req_d) begin
         moves++;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R4 unexpected move", mv_addr, 32'h0);
         end else begin
            logic [95:0] e;
            e = exp_q.pop_front();
            chk(cur_ptr == e[95:64], "R6/R7 move pointer", cur_ptr, e[95:64]);
            chk(mv_addr == e[63:32], "R4 move address", mv_addr, e[63:32]);
            chk(32'(mv_len) == e[31:0], "R4 move length", 32'(mv_len), e[31:0]);
         end
      end
   end

   task automatic set_rxen(input bit v);
      @(negedge clk); sw_rxen_wr = 1'b1; sw_rxen_val = v;
      @(negedge clk); sw_rxen_wr = 1'b0;
   endtask

   task automatic wait_halt();
      for (int i = 0; i < 500 && !halted; i++) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      // D0 @0x100, D1 @0x110, D2 @0x120 (list end)
      mem[8'h40] = 32'h8012_0000; mem[8'h41] = 32'd64;  mem[8'h42] = 32'h1000;
      mem[8'h44] = 32'h8000_0000; mem[8'h45] = 32'd100; mem[8'h46] = 32'h2000;
      mem[8'h48] = 32'hC034_0000; mem[8'h49] = 32'd200; mem[8'h4A] = 32'h3000;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rxen == 1'b0, "R1 rxen", 32'(rxen), 0);
      chk(halted == 1'b0, "R1 halted", 32'(halted), 0);
      chk(cur_ptr == '0, "R1 cur_ptr", cur_ptr, 0);
      chk(!mem_req && !mv_req, "R1 idle ports", {mem_req, mv_req}, 0);
      rst_n = 1'b1;

      @(negedge clk); sw_base_wr = 1'b1; sw_base_val = 32'h100;
      @(negedge clk); sw_base_wr = 1'b0;
      set_rxen(1'b1);
      repeat (10) @(negedge clk);
      chk(reads == 0, "R3 no fetch without frame", reads, 0);
      chk(cur_ptr == 32'h100, "R2 pointer loaded from base", cur_ptr, 32'h100);

      // walk D0, D1, D2, wrap to D0 which is now returned -> halt
      expect_move(32'h100, 32'h1000, 64);
      expect_move(32'h110, 32'h2000, 100);
      expect_move(32'h120, 32'h3000, 200);
      frame_avail = 1'b1;
      wait_halt();
      chk(halted == 1'b1, "R8 halted", 32'(halted), 1);
      chk(rxen == 1'b0, "R8 rxen cleared", 32'(rxen), 0);
      chk(cur_ptr == 32'h100, "R7/R8 pointer wrapped and held", cur_ptr, 32'h100);
      chk(mem[8'h40] == 32'h0012_003C, "R5 D0 write-back", mem[8'h40], 32'h0012_003C);
      chk(mem[8'h44] == 32'h0000_0060, "R5 D1 write-back", mem[8'h44], 32'h0000_0060);
      chk(mem[8'h48] == 32'h4034_00C4, "R5 D2 write-back keeps list end", mem[8'h48], 32'h4034_00C4);
      chk(moves == 3, "R6 move count", moves, 3);

      // R9 resume at held pointer
      mem[8'h40] = 32'h8000_0000;
      expect_move(32'h100, 32'h1000, 64);
      set_rxen(1'b1);
      chk(halted == 1'b0, "R9 halted cleared", 32'(halted), 0);
      wait_halt();
      chk(moves == 4, "R9 refetch same descriptor", moves, 4);
      chk(cur_ptr == 32'h110, "R8 held at invalid D1", cur_ptr, 32'h110);
      chk(mem[8'h44] == 32'h0000_0060, "R8 no write on invalid", mem[8'h44], 32'h0000_0060);
      chk(mem[8'h40] == 32'h0000_003C, "R5 D0 second write-back", mem[8'h40], 32'h0000_003C);

      // R10 software stop mid-transfer
      mem[8'h44] = 32'h8000_0000;
      mem[8'h48] = 32'hC034_0000;
      expect_move(32'h110, 32'h2000, 100);
      set_rxen(1'b1);
      for (int i = 0; i < 200 && !mv_req; i++) @(negedge clk);
      set_rxen(1'b0);
      repeat (40) @(negedge clk);
      chk(mem[8'h44] == 32'h0000_0060, "R10 current descriptor completed", mem[8'h44], 32'h0000_0060);
      chk(mem[8'h48] == 32'hC034_0000, "R10 next descriptor untouched", mem[8'h48], 32'hC034_0000);
      chk(cur_ptr == 32'h120, "R6 pointer advanced by 16", cur_ptr, 32'h120);
      chk(moves == 5, "R10 no further move", moves, 5);
      chk(halted == 1'b0 && rxen == 1'b0, "R10 stopped cleanly", {halted, rxen}, 0);
      chk(exp_q.size() == 0, "R4 all expected moves seen", exp_q.size(), 0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog act=%h exp=%h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule